// File: doc/BRIEF.md
# Floppy Drive-Control Register Block

This block holds the host-visible drive-control state of a PC-compatible floppy controller. The host writes it over a simple synchronous register bus. It holds a drive-control register that carries the drive number, a DMA gate bit and four motor bits, and two separate data-rate registers. From these it drives the drive-select pins, the motor pins, the two data-rate pins, the DMA request and acknowledge qualifiers and the head-direction pin.

A compatibility-mode input decides whether DMA is gated by the drive-control register or is always open. A four-drive input changes the drive and motor pins from two directly decoded drives to an encoded form that an external decoder expands to four drives. The data-rate pins follow whichever rate register the host wrote most recently. The seek engine feeds the direction pin, and the data engine feeds the raw DMA request.

Top module: `fdc_drive_ctl`

## Requirements
- R1: While reset is held and after it, the drive-control register and both rate registers are zero. The drive-select and motor pins are then all high, the rate pins are 00 and the DMA request pin is low.
- R2: In two-drive mode (four-drive input low), drive-select pin i (i = 0, 1) is low exactly when drive-control bits [1:0] equal i and motor bit 4+i is set. Drive numbers 2 and 3 pull no select pin low.
- R3: In two-drive mode, motor pin i is the inverse of drive-control bit 4+i.
- R4: In four-drive mode, a drive is live when the motor bit of the selected drive (bit 4 + drive number) is set. While live, the select pins carry the drive number (bits [1:0]), and otherwise they read 11. Motor pin 0 is low exactly while live. Motor pin 1 is low while any of bits [7:4] is set.
- R5: The rate pins show bits [1:0] of the rate register written last. The two rate registers sit at offsets 7 and 4. A write to any other offset leaves the rate pins unchanged, and upper data bits have no effect.
- R6: In compatibility modes 00 and 01 (and the unused code 11), drive-control bit 3 gates both the DMA request output and the acknowledge qualifier.
- R7: In compatibility mode 10, DMA request and acknowledge pass regardless of drive-control bit 3.
- R8: While DMA is not enabled under the current mode, the request output is low and an asserted (low) acknowledge input leaves the acknowledge qualifier low.
- R9: The direction pin is low (step in) only while a seek is active, the head moves inward and no read or write is active. It is high in every other case.
- R10: Reading offset 2 returns the stored drive-control register. Reading either rate register, or any other offset, returns zero.
- R11: A register write is visible on the pins from the clock edge that samples the write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| compat_mode | input | 2 | 00 AT, 01 Model 30, 10 PS/2, 11 treated as AT |
| four_drive_en | input | 1 | Encoded four-drive pin mode |
| seek_active | input | 1 | Seek in progress |
| seek_inward | input | 1 | Seek moves the head inward |
| rw_active | input | 1 | Read or write transfer in progress |
| dma_req_in | input | 1 | Raw DMA request from the data path |
| dma_ack_n | input | 1 | DMA acknowledge, active low |
| drv_sel_n | output | 2 | Drive-select pins, active low |
| mot_en_n | output | 2 | Motor pins, active low |
| rate_sel | output | 2 | Selected data-rate code |
| dir_n | output | 1 | Head direction, low = step in |
| dma_req_out | output | 1 | Gated DMA request |
| dma_ack_ok | output | 1 | Acknowledge accepted, active high |

## Verification
Every register-driven pin and the readback change on the rising edge that samples the write strobe. The bench drives the bus on the falling edge, holds the strobe for one cycle and samples at the next falling edge, one register stage later. The DMA, direction and readback paths have no register between their inputs and outputs. For those, the bench changes the input on a falling edge and samples half a period later, before any rising edge. The last-writer rule is checked by alternating writes to the two rate registers, with a drive-control write in between.

// File: rtl/fdc_ctl_pkg.sv
package fdc_ctl_pkg;
  localparam int DATA_W   = 8;
  localparam int MAX_DRV  = 4;
  localparam int SEL_W    = $clog2(MAX_DRV);
  localparam int MOT_LSB  = 4;
  localparam int DMA_BIT  = 3;
  localparam int RATE_W   = 2;
  localparam int PIN_CNT  = 2;

  typedef enum logic [1:0] {
    MODE_AT   = 2'b00,
    MODE_M30  = 2'b01,
    MODE_PS2  = 2'b10,
    MODE_RSVD = 2'b11
  } compat_e;

  // DMA is open in PS/2 mode, otherwise follows the gate bit.
  function automatic logic dma_allowed(input logic [1:0] mode, input logic gate_bit);
    return (mode == MODE_PS2) ? 1'b1 : gate_bit;
  endfunction

  // Motor bit belonging to the currently selected drive.
  function automatic logic drive_live(input logic [DATA_W-1:0] ctl);
    logic [MAX_DRV-1:0] motors;
    motors = ctl[MOT_LSB +: MAX_DRV];
    return motors[ctl[SEL_W-1:0]];
  endfunction
endpackage

// File: rtl/fdc_reg_file.sv
module fdc_reg_file
  import fdc_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 3,
  parameter logic [ADDR_W-1:0] CTL_ADDR  = 3'd2,
  parameter logic [ADDR_W-1:0] RATEA_ADDR = 3'd4,
  parameter logic [ADDR_W-1:0] RATEB_ADDR = 3'd7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] ctl_o,
  output logic [RATE_W-1:0] rate_o
);
  logic [DATA_W-1:0] ctl_q;
  logic [RATE_W-1:0] ratea_q, rateb_q;
  logic              ratea_last_q;
  logic              hit_ctl, hit_ratea, hit_rateb;

  assign hit_ctl   = wr && (addr == CTL_ADDR);
  assign hit_ratea = wr && (addr == RATEA_ADDR);
  assign hit_rateb = wr && (addr == RATEB_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q        <= '0;
      ratea_q      <= '0;
      rateb_q      <= '0;
      ratea_last_q <= 1'b0;
    end else begin
      if (hit_ctl) ctl_q <= wdata;
      if (hit_ratea) begin
        ratea_q      <= wdata[RATE_W-1:0];
        ratea_last_q <= 1'b1;
      end else if (hit_rateb) begin
        rateb_q      <= wdata[RATE_W-1:0];
        ratea_last_q <= 1'b0;
      end
    end
  end

  assign ctl_o  = ctl_q;
  assign rate_o = ratea_last_q ? ratea_q : rateb_q;
  assign rdata  = (addr == CTL_ADDR) ? ctl_q : '0;

  assert_ctl_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    hit_ctl |=> (ctl_o == $past(wdata)));
  assert_ratea_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hit_ratea |=> (rate_o == $past(wdata[RATE_W-1:0])));
  assert_rateb_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hit_rateb |=> (rate_o == $past(wdata[RATE_W-1:0])));
  assert_rate_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit_ratea && !hit_rateb) |=> $stable(rate_o));
endmodule

// File: rtl/fdc_drive_decode.sv
module fdc_drive_decode
  import fdc_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] ctl,
  input  logic              four_mode,
  output logic [PIN_CNT-1:0] sel_n,
  output logic [PIN_CNT-1:0] mot_n
);
  logic [PIN_CNT-1:0] two_sel_n, two_mot_n;
  logic [PIN_CNT-1:0] four_sel_n, four_mot_n;
  logic               live;

  for (genvar i = 0; i < PIN_CNT; i++) begin : g_pin
    assign two_sel_n[i] = ~((ctl[SEL_W-1:0] == SEL_W'(i)) && ctl[MOT_LSB+i]);
    assign two_mot_n[i] = ~ctl[MOT_LSB+i];
  end

  assign live       = drive_live(ctl);
  assign four_sel_n = live ? ctl[SEL_W-1:0] : '1;
  assign four_mot_n = {~(|ctl[MOT_LSB +: MAX_DRV]), ~live};

  assign sel_n = four_mode ? four_sel_n : two_sel_n;
  assign mot_n = four_mode ? four_mot_n : two_mot_n;

  assert_two_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !four_mode |-> $onehot0(~sel_n));
  for (genvar i = 0; i < PIN_CNT; i++) begin : g_chk
    assert_sel_needs_motor_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!four_mode && !sel_n[i]) |-> !mot_n[i]);
  end
  assert_four_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (four_mode && (ctl[MOT_LSB +: MAX_DRV] == '0)) |-> (sel_n == '1 && mot_n == '1));
  assert_four_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (four_mode && !mot_n[0]) |-> !mot_n[1]);
endmodule

// File: rtl/fdc_dma_gate.sv
module fdc_dma_gate
  import fdc_ctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       gate_bit,
  input  logic       req_in,
  input  logic       ack_n,
  output logic       req_out,
  output logic       ack_ok
);
  logic dma_on;

  assign dma_on  = dma_allowed(mode, gate_bit);
  assign req_out = req_in & dma_on;
  assign ack_ok  = ~ack_n & dma_on;

  assert_ps2_open_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_PS2 && req_in && !ack_n) |-> (req_out && ack_ok));
  assert_gate_closed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != MODE_PS2 && !gate_bit) |-> (!req_out && !ack_ok));
  assert_no_spurious_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !req_in |-> !req_out);
endmodule

// File: rtl/fdc_drive_ctl.sv
module fdc_drive_ctl
  import fdc_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 3,
  parameter logic [ADDR_W-1:0] CTL_ADDR   = 3'd2,
  parameter logic [ADDR_W-1:0] RATEA_ADDR = 3'd4,
  parameter logic [ADDR_W-1:0] RATEB_ADDR = 3'd7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [1:0]        compat_mode,
  input  logic              four_drive_en,
  input  logic              seek_active,
  input  logic              seek_inward,
  input  logic              rw_active,
  input  logic              dma_req_in,
  input  logic              dma_ack_n,
  output logic [1:0]        drv_sel_n,
  output logic [1:0]        mot_en_n,
  output logic [1:0]        rate_sel,
  output logic              dir_n,
  output logic              dma_req_out,
  output logic              dma_ack_ok
);
  logic [DATA_W-1:0] ctl;

  fdc_reg_file #(
    .ADDR_W(ADDR_W), .CTL_ADDR(CTL_ADDR),
    .RATEA_ADDR(RATEA_ADDR), .RATEB_ADDR(RATEB_ADDR)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr),
    .wdata(bus_wdata), .rdata(bus_rdata), .ctl_o(ctl), .rate_o(rate_sel)
  );

  fdc_drive_decode u_dec (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .four_mode(four_drive_en),
    .sel_n(drv_sel_n), .mot_n(mot_en_n)
  );

  fdc_dma_gate u_dma (
    .clk(clk), .rst_n(rst_n), .mode(compat_mode), .gate_bit(ctl[DMA_BIT]),
    .req_in(dma_req_in), .ack_n(dma_ack_n),
    .req_out(dma_req_out), .ack_ok(dma_ack_ok)
  );

  assign dir_n = ~(seek_active & ~rw_active & seek_inward);

  assert_dir_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!seek_active || rw_active || !seek_inward) |-> dir_n);
  assert_dir_inward_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (seek_active && !rw_active && seek_inward) |-> !dir_n);
  assert_read_rate_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == RATEA_ADDR || bus_addr == RATEB_ADDR) |-> (bus_rdata == '0));
endmodule

// File: tb/sim_fdc_drive_ctl.sv
module sim_fdc_drive_ctl;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 11;
  // {four, ctl[7:0], expected sel_n[1:0], expected mot_n[1:0]}
  localparam logic [12:0] VEC [NV] = '{
    {1'b0, 8'h00, 2'b11, 2'b11},
    {1'b0, 8'h10, 2'b10, 2'b10},
    {1'b0, 8'h20, 2'b11, 2'b01},
    {1'b0, 8'h21, 2'b01, 2'b01},
    {1'b0, 8'h32, 2'b11, 2'b00},
    {1'b0, 8'hF1, 2'b01, 2'b00},
    {1'b1, 8'h00, 2'b11, 2'b11},
    {1'b1, 8'h80, 2'b11, 2'b01},
    {1'b1, 8'h83, 2'b11, 2'b00},
    {1'b1, 8'h42, 2'b10, 2'b00},
    {1'b1, 8'h10, 2'b00, 2'b00}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic [1:0] compat_mode = 2'b00;
  logic four_drive_en = 1'b0, seek_active = 1'b0, seek_inward = 1'b0, rw_active = 1'b0;
  logic dma_req_in = 1'b0, dma_ack_n = 1'b1;
  logic [1:0] drv_sel_n, mot_en_n, rate_sel;
  logic dir_n, dma_req_out, dma_ack_ok;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fdc_drive_ctl u0 (.*);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got hang expected completion");
    finish_run();
  end

  initial begin
    dma_req_in = 1'b1;
    repeat (2) @(negedge clk);
    // R1: during reset
    chk("R1", {6'b0, drv_sel_n}, 8'h03);
    chk("R1", {6'b0, mot_en_n}, 8'h03);
    chk("R1", {6'b0, rate_sel}, 8'h00);
    chk("R1", {7'b0, dma_req_out}, 8'h00);
    bus_addr = 3'd2;
    #1 chk("R1", bus_rdata, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R1", {6'b0, drv_sel_n}, 8'h03);

    // R2 R3 R4 R11: table walk
    for (int k = 0; k < NV; k++) begin
      four_drive_en = VEC[k][12];
      wr(3'd2, VEC[k][11:4]);
      chk(VEC[k][12] ? "R4" : "R2", {6'b0, drv_sel_n}, {6'b0, VEC[k][3:2]});
      chk(VEC[k][12] ? "R4" : "R3", {6'b0, mot_en_n}, {6'b0, VEC[k][1:0]});
    end
    four_drive_en = 1'b0;

    // R5: last rate writer wins
    wr(3'd7, 8'h02); chk("R5", {6'b0, rate_sel}, 8'h02);
    wr(3'd4, 8'h01); chk("R5", {6'b0, rate_sel}, 8'h01);
    wr(3'd2, 8'h00); chk("R5", {6'b0, rate_sel}, 8'h01);
    wr(3'd7, 8'h03); chk("R5", {6'b0, rate_sel}, 8'h03);
    wr(3'd7, 8'hFC); chk("R5", {6'b0, rate_sel}, 8'h00);
    wr(3'd4, 8'h02); chk("R5", {6'b0, rate_sel}, 8'h02);

    // R10: readback
    wr(3'd2, 8'h5A);
    bus_addr = 3'd2; #1 chk("R10", bus_rdata, 8'h5A);
    bus_addr = 3'd4; #1 chk("R10", bus_rdata, 8'h00);
    bus_addr = 3'd7; #1 chk("R10", bus_rdata, 8'h00);
    bus_addr = 3'd5; #1 chk("R10", bus_rdata, 8'h00);

    // R6 R8: AT mode, gate bit clear then set
    wr(3'd2, 8'h00);
    compat_mode = 2'b00; dma_req_in = 1'b1; dma_ack_n = 1'b0;
    #1 chk("R8", {6'b0, dma_req_out, dma_ack_ok}, 8'h00);
    wr(3'd2, 8'h08);
    chk("R6", {6'b0, dma_req_out, dma_ack_ok}, 8'h03);
    compat_mode = 2'b01;
    #1 chk("R6", {6'b0, dma_req_out, dma_ack_ok}, 8'h03);
    wr(3'd2, 8'h00);
    chk("R6", {6'b0, dma_req_out, dma_ack_ok}, 8'h00);
    compat_mode = 2'b11;
    #1 chk("R8", {6'b0, dma_req_out, dma_ack_ok}, 8'h00);

    // R7: PS/2 mode ignores gate bit
    compat_mode = 2'b10;
    #1 chk("R7", {6'b0, dma_req_out, dma_ack_ok}, 8'h03);
    dma_ack_n = 1'b1;
    #1 chk("R7", {6'b0, dma_req_out, dma_ack_ok}, 8'h02);
    dma_req_in = 1'b0;
    #1 chk("R7", {6'b0, dma_req_out, dma_ack_ok}, 8'h00);

    // R9: direction pin
    @(negedge clk);
    seek_active = 1'b1; seek_inward = 1'b1; rw_active = 1'b0;
    #1 chk("R9", {7'b0, dir_n}, 8'h00);
    seek_inward = 1'b0;
    #1 chk("R9", {7'b0, dir_n}, 8'h01);
    seek_inward = 1'b1; rw_active = 1'b1;
    #1 chk("R9", {7'b0, dir_n}, 8'h01);
    seek_active = 1'b0; rw_active = 1'b0;
    #1 chk("R9", {7'b0, dir_n}, 8'h01);

    // R1: reset again clears stored state
    wr(3'd2, 8'h11); wr(3'd4, 8'h03);
    @(negedge clk); rst_n = 1'b0;
    #1 chk("R1", {2'b0, drv_sel_n, mot_en_n, rate_sel}, 8'h3C);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    finish_run();
  end
endmodule